// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers a set of device interrupt lines and one non-maskable line. It tracks the priority level of the handler now running and offers a single interrupt request to the CPU. Each device line has a fixed level, and so does the non-maskable line. A pending line is offered only when its level is strictly above the running level. A line that is too low stays pending until the running handlers have returned.

When the CPU acknowledges the offer, the controller runs a vector fetch. It strobes an acknowledge to the winning device and waits for that device to return a vector. The CPU then uses the vector to pick a handler from its table. If the device stays silent for a programmable number of cycles, the controller reports a bus error and enters no handler. The non-maskable line needs no fetch, because its vector is a fixed parameter. Each entry saves the running level on a small stack and sets a bit in an in-service register. A return strobe from the CPU pops the saved level back and clears that bit.

The control is a three-state machine:

- `ST_IDLE`: waiting for a request.
- `ST_OFFER`: the request is shown to the CPU.
- `ST_FETCH`: the device acknowledge is held.

It has six transitions:

- *recognise*: `ST_IDLE` to `ST_OFFER`.
- *withdraw*: `ST_OFFER` to `ST_IDLE`, when no line qualifies any more.
- *grant-device*: `ST_OFFER` to `ST_FETCH`.
- *grant-nmi*: `ST_OFFER` to `ST_IDLE`, with the fixed vector.
- *vector-in*: `ST_FETCH` to `ST_IDLE`.
- *time-out*: `ST_FETCH` to `ST_IDLE`, with a bus error.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the following outputs are low: `cpu_irq`, `dev_ack`, `vec_valid`, `bus_err`, `svc_latch`, `stack_ovf`. `cur_prio` reads 0.
- R2: Device line i has level NUM_LINES-i. With four lines, line 0 is level 4 and line 3 is level 1. No handler active means level 0. A line is offered only if its level is strictly greater than `cur_prio`. A lower or equal line stays pending and is offered once returns bring `cur_prio` below it.
- R3: The non-maskable line has level NUM_LINES+1 (5 by default) and is never masked by a device level. On `cpu_ack` it produces `vec_valid` with `vec_out` equal to NMI_VEC (0xFF by default) on the next cycle. It asserts no `dev_ack`, and `cur_prio` becomes NUM_LINES+1.
- R4: When several device lines qualify together, the lowest-numbered line wins.
- R5: A request sampled at one rising edge is registered there. `cpu_irq` goes high after the second rising edge and not after the first.
- R6: `cpu_ack` while `cpu_irq` is high starts a fetch. From the next cycle `dev_ack` holds the one-hot bit of the winning line (bit i for line i) until the fetch ends. `dev_ack` is never high while `cpu_irq` is high.
- R7: `dev_vec_valid` during a fetch ends it. On the next cycle `vec_valid` pulses for one cycle with `vec_out` equal to `dev_vec`, and `dev_ack` drops. `cur_prio` becomes the winner's level, and `svc_latch` sets bit i for line i or bit NUM_LINES for the non-maskable line.
- R8: If no vector arrives, `dev_ack` stays high for exactly `tmo_cycles` cycles (16 in the bench). Then `bus_err` pulses for one cycle, and `cur_prio` and `svc_latch` stay unchanged.
- R9: Pending state follows the level of the line. If the line drops while offered, `cpu_irq` falls two rising edges later. A later `cpu_ack` then yields no `dev_ack` and no vector.
- R10: `rti` in `ST_IDLE` clears the `svc_latch` bit of the current level and restores the most recently saved level into `cur_prio`. With `cur_prio` at 0, `rti` changes nothing.
- R11: The save stack holds STACK_DEPTH (4) levels. An entry taken with the stack full discards its save and sets `stack_ovf`. The next return therefore restores the last level that was saved. `stack_ovf` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | NUM_LINES | Level request per device line |
| nmi_req | input | 1 | Non-maskable request |
| cpu_ack | input | 1 | CPU accepts the offered interrupt |
| rti | input | 1 | Return-from-interrupt strobe |
| tmo_cycles | input | TMO_W | Vector fetch time-out in cycles |
| dev_vec_valid | input | 1 | Device presents a vector |
| dev_vec | input | VEC_W | Vector from the device |
| cpu_irq | output | 1 | Interrupt offered to the CPU |
| dev_ack | output | NUM_LINES | One-hot acknowledge to the winning device |
| vec_valid | output | 1 | One-cycle pulse, vector ready |
| vec_out | output | VEC_W | Vector for the handler table |
| bus_err | output | 1 | One-cycle pulse, fetch timed out |
| cur_prio | output | LVL_W | Level of the running handler |
| svc_latch | output | NUM_LINES+1 | In-service bits, top bit for the non-maskable line |
| stack_ovf | output | 1 | Sticky save-stack overflow |

## Verification
The assertions take for granted that the environment behaves in four ways:

- `tmo_cycles` is at least 1 and does not change during a fetch.
- A device raises `dev_vec_valid` only while its `dev_ack` is high.
- The CPU pulses `rti` only while the controller is idle.
- `cpu_ack` is meaningful only while an offer is up.

The stimulus keeps within these limits. It drives every input at the falling edge and holds the time-out at 16 for the whole run. It issues `rti` only after each fetch has finished, and it supplies vectors only in the cycle after it has seen `dev_ack`. The one deliberate stray `cpu_ack`, given after a withdrawn offer, is sent to show that it is ignored.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_FETCH = 2'd2
    } irqv_state_e;

endpackage

// File: rtl/irqv_req_arbiter.sv
module irqv_req_arbiter #(
    parameter int NUM_LINES = 4,
    parameter int LVL_W     = 3,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_req,
    input  logic                 nmi_req,
    input  logic [LVL_W-1:0]     cur_lvl,
    output logic                 pick_valid,
    output logic                 pick_nmi,
    output logic [IDX_W-1:0]     pick_idx,
    output logic [LVL_W-1:0]     pick_lvl
);

    localparam int NMI_LVL = NUM_LINES + 1;

    logic [NUM_LINES-1:0] req_q;
    logic                 nmi_q;
    logic                 found;

    // one register stage: requests are latched, then recognised next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            req_q <= dev_req;
            nmi_q <= nmi_req;
        end
    end

    // fixed priority: scan downwards so the lowest index is kept last
    always_comb begin
        found    = 1'b0;
        pick_nmi = 1'b0;
        pick_idx = '0;
        pick_lvl = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req_q[i]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(i);
                pick_lvl = LVL_W'(NUM_LINES - i);
            end
        end
        if (nmi_q) begin
            found    = 1'b1;
            pick_nmi = 1'b1;
            pick_lvl = LVL_W'(NMI_LVL);
        end
        pick_valid = found && (pick_lvl > cur_lvl);
    end

    // R4: a chosen device line always has an active registered request
    p_pick_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && !pick_nmi) |-> req_q[pick_idx]);

endmodule

// File: rtl/irqv_prio_stack.sv
module irqv_prio_stack #(
    parameter int NUM_LINES   = 4,
    parameter int STACK_DEPTH = 4,
    parameter int LVL_W       = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [LVL_W-1:0]   new_lvl,
    input  logic               pop,
    output logic [LVL_W-1:0]   cur_lvl,
    output logic [NUM_LINES:0] svc_latch,
    output logic               ovf
);

    localparam int NMI_LVL = NUM_LINES + 1;
    localparam int SP_W    = $clog2(STACK_DEPTH + 1);

    logic [LVL_W-1:0] saved [STACK_DEPTH];
    logic [SP_W-1:0]  sp;
    logic [LVL_W-1:0] top_lvl;
    logic             full;

    function automatic logic [NUM_LINES:0] lvl_mask(input logic [LVL_W-1:0] lvl);
        logic [NUM_LINES:0] m;
        m = '0;
        for (int b = 0; b < NUM_LINES; b++) begin
            if (lvl == LVL_W'(NUM_LINES - b)) m[b] = 1'b1;
        end
        if (lvl == LVL_W'(NMI_LVL)) m[NUM_LINES] = 1'b1;
        return m;
    endfunction

    assign full = (sp == SP_W'(STACK_DEPTH));

    always_comb begin
        top_lvl = '0;
        for (int k = 0; k < STACK_DEPTH; k++) begin
            if (sp == SP_W'(k + 1)) top_lvl = saved[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_lvl   <= '0;
            sp        <= '0;
            svc_latch <= '0;
            ovf       <= 1'b0;
            for (int k = 0; k < STACK_DEPTH; k++) saved[k] <= '0;
        end else if (push) begin
            if (full) begin
                ovf <= 1'b1;
            end else begin
                for (int k = 0; k < STACK_DEPTH; k++) begin
                    if (sp == SP_W'(k)) saved[k] <= cur_lvl;
                end
                sp <= sp + SP_W'(1);
            end
            cur_lvl   <= new_lvl;
            svc_latch <= svc_latch | lvl_mask(new_lvl);
        end else if (pop && cur_lvl != '0) begin
            svc_latch <= svc_latch & ~lvl_mask(cur_lvl);
            if (sp != '0) begin
                cur_lvl <= top_lvl;
                sp      <= sp - SP_W'(1);
            end else begin
                cur_lvl <= '0;
            end
        end
    end

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    p_sp_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(STACK_DEPTH));
    p_push_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (cur_lvl > $past(cur_lvl)));
    p_return_lowers_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cur_lvl != '0) |=> (cur_lvl < $past(cur_lvl)));

endmodule

// File: rtl/irqv_vec_timer.sv
module irqv_vec_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && cnt != '1) begin
            cnt <= cnt + TMO_W'(1);
        end
    end

    assign cnt_next = {1'b0, cnt} + (TMO_W + 1)'(1);
    assign expired  = run && (cnt_next >= {1'b0, limit});

    // R8: the wait never counts past the programmed window (limit held stable)
    p_cnt_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int STACK_DEPTH = 4,
    parameter int VEC_W       = 8,
    parameter int TMO_W       = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_req,
    input  logic                 nmi_req,
    input  logic                 cpu_ack,
    input  logic                 rti,
    input  logic [TMO_W-1:0]     tmo_cycles,
    input  logic                 dev_vec_valid,
    input  logic [VEC_W-1:0]     dev_vec,
    output logic                 cpu_irq,
    output logic [NUM_LINES-1:0] dev_ack,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 bus_err,
    output logic [$clog2(NUM_LINES+2)-1:0] cur_prio,
    output logic [NUM_LINES:0]   svc_latch,
    output logic                 stack_ovf
);

    localparam int LVL_W = $clog2(NUM_LINES + 2);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    irqv_state_e      state_q, state_d;
    logic             pick_valid, pick_nmi;
    logic [IDX_W-1:0] pick_idx, win_idx_q, ack_idx;
    logic [LVL_W-1:0] pick_lvl, win_lvl_q, push_lvl;
    logic             do_push, do_pop, tmr_start, tmr_expired, fetch_tmo;

    irqv_req_arbiter #(
        .NUM_LINES (NUM_LINES),
        .LVL_W     (LVL_W),
        .IDX_W     (IDX_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_req    (dev_req),
        .nmi_req    (nmi_req),
        .cur_lvl    (cur_prio),
        .pick_valid (pick_valid),
        .pick_nmi   (pick_nmi),
        .pick_idx   (pick_idx),
        .pick_lvl   (pick_lvl)
    );

    irqv_prio_stack #(
        .NUM_LINES   (NUM_LINES),
        .STACK_DEPTH (STACK_DEPTH),
        .LVL_W       (LVL_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .new_lvl   (push_lvl),
        .pop       (do_pop),
        .cur_lvl   (cur_prio),
        .svc_latch (svc_latch),
        .ovf       (stack_ovf)
    );

    irqv_vec_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (state_q == ST_FETCH),
        .limit   (tmo_cycles),
        .expired (tmr_expired)
    );

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        push_lvl  = pick_lvl;
        tmr_start = 1'b0;
        fetch_tmo = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                do_pop = rti;
                if (pick_valid) state_d = ST_OFFER;              // recognise
            end
            ST_OFFER: begin
                if (!pick_valid) begin
                    state_d = ST_IDLE;                           // withdraw
                end else if (cpu_ack) begin
                    if (pick_nmi) begin
                        do_push = 1'b1;                          // grant-nmi
                        state_d = ST_IDLE;
                    end else begin
                        tmr_start = 1'b1;                        // grant-device
                        state_d   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (dev_vec_valid) begin
                    do_push  = 1'b1;                             // vector-in
                    push_lvl = win_lvl_q;
                    state_d  = ST_IDLE;
                end else if (tmr_expired) begin
                    fetch_tmo = 1'b1;                            // time-out
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ack_idx = tmr_start ? pick_idx : win_idx_q;
    assign cpu_irq = (state_q == ST_OFFER);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            win_idx_q <= '0;
            win_lvl_q <= '0;
        end else begin
            state_q <= state_d;
            if (tmr_start) begin
                win_idx_q <= pick_idx;
                win_lvl_q <= pick_lvl;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_ack   <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
            bus_err   <= 1'b0;
        end else begin
            dev_ack   <= (state_d == ST_FETCH) ?
                         ({{(NUM_LINES-1){1'b0}}, 1'b1} << ack_idx) : '0;
            vec_valid <= do_push;
            bus_err   <= fetch_tmo;
            if (do_push) vec_out <= (state_q == ST_OFFER) ? NMI_VEC : dev_vec;
        end
    end

    p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));
    p_no_ack_on_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (dev_ack == '0));
    p_vec_or_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && bus_err));
    p_err_follows_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(dev_ack) != '0));
    p_err_keeps_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(cur_prio));
    p_entry_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (cur_prio > $past(cur_prio)));
    p_nmi_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && svc_latch[NUM_LINES] && !$past(svc_latch[NUM_LINES]))
            |-> (vec_out == NMI_VEC));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 4;
    localparam int TMO        = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] dev_req = '0;
    logic          nmi_req = 1'b0;
    logic          cpu_ack = 1'b0;
    logic          rti = 1'b0;
    logic [7:0]    tmo_cycles = 8'(TMO);
    logic          dev_vec_valid = 1'b0;
    logic [7:0]    dev_vec = '0;
    logic          cpu_irq;
    logic [NL-1:0] dev_ack;
    logic          vec_valid;
    logic [7:0]    vec_out;
    logic          bus_err;
    logic [2:0]    cur_prio;
    logic [NL:0]   svc_latch;
    logic          stack_ovf;

    typedef struct {
        bit         is_err;
        logic [7:0] vec;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_req       (dev_req),
        .nmi_req       (nmi_req),
        .cpu_ack       (cpu_ack),
        .rti           (rti),
        .tmo_cycles    (tmo_cycles),
        .dev_vec_valid (dev_vec_valid),
        .dev_vec       (dev_vec),
        .cpu_irq       (cpu_irq),
        .dev_ack       (dev_ack),
        .vec_valid     (vec_valid),
        .vec_out       (vec_out),
        .bus_err       (bus_err),
        .cur_prio      (cur_prio),
        .svc_latch     (svc_latch),
        .stack_ovf     (stack_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every vector or bus error must match the next expected item
    always @(negedge clk) begin
        if (rst_n && (vec_valid || bus_err)) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected event (vec_valid,bus_err)", {vec_valid, bus_err}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R8 event kind bus_err", bus_err, e.is_err);
                if (!e.is_err) chk("R7 vec_out", vec_out, e.vec);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string tag);
        for (int k = 0; k < 8 && !cpu_irq; k++) @(negedge clk);
        chk(tag, cpu_irq, 1);
    endtask

    task automatic serve_dev(input int line, input logic [7:0] v, input string tag);
        wait_irq({tag, " cpu_irq"});
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk({tag, " dev_ack one-hot"}, dev_ack, 32'(1) << line);
        exp_q.push_back('{1'b0, v});
        dev_vec_valid = 1'b1;
        dev_vec       = v;
        @(negedge clk);
        dev_vec_valid = 1'b0;
        chk({tag, " dev_ack released"}, dev_ack, 0);
        chk({tag, " cur_prio"}, cur_prio, NL - line);
        chk({tag, " svc_latch bit"}, svc_latch[line], 1);
    endtask

    task automatic serve_nmi(input string tag);
        wait_irq({tag, " cpu_irq"});
        exp_q.push_back('{1'b0, 8'hFF});
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk({tag, " no dev_ack"}, dev_ack, 0);
        chk({tag, " cur_prio"}, cur_prio, NL + 1);
        chk({tag, " svc_latch nmi bit"}, svc_latch[NL], 1);
    endtask

    task automatic do_rti();
        rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 cpu_irq", cpu_irq, 0);
        chk("R1 dev_ack", dev_ack, 0);
        chk("R1 cur_prio", cur_prio, 0);
        chk("R1 svc_latch", svc_latch, 0);
        chk("R1 stack_ovf", stack_ovf, 0);
        chk("R1 vec_valid/bus_err", {vec_valid, bus_err}, 0);

        // R5 latency, then R7 service of line 2
        dev_req[2] = 1'b1;
        @(negedge clk);
        chk("R5 cpu_irq after one edge", cpu_irq, 0);
        @(negedge clk);
        chk("R5 cpu_irq after two edges", cpu_irq, 1);
        serve_dev(2, 8'h22, "R7 line2");
        chk("R7 svc_latch", svc_latch, 5'b00100);
        dev_req[2] = 1'b0;

        // R2 lower line is masked and stays pending
        dev_req[3] = 1'b1;
        tick(4);
        chk("R2 line3 masked", cpu_irq, 0);

        // R4 simultaneous lines 0 and 1
        dev_req[0] = 1'b1;
        dev_req[1] = 1'b1;
        serve_dev(0, 8'h10, "R4 line0 wins");
        dev_req[0] = 1'b0;
        tick(4);
        chk("R2 line1 masked by level 4", cpu_irq, 0);

        // R3 non-maskable over level 4
        nmi_req = 1'b1;
        serve_nmi("R3 nmi");
        chk("R3 svc_latch", svc_latch, 5'b10101);
        nmi_req = 1'b0;
        tick(3);

        // R10 returns
        do_rti();
        chk("R10 cur_prio after return", cur_prio, 4);
        chk("R10 nmi bit cleared", svc_latch, 5'b00101);
        tick(2);
        chk("R2 line1 still masked", cpu_irq, 0);
        do_rti();
        chk("R10 cur_prio after second return", cur_prio, 2);
        chk("R10 line0 bit cleared", svc_latch, 5'b00100);

        // R2 pending line1 now offered; R8 time-out
        wait_irq("R2 pending line1 offered");
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R6 dev_ack line1", dev_ack, 4'b0010);
        exp_q.push_back('{1'b1, 8'h00});
        dev_req[1] = 1'b0;
        begin
            int cnt;
            cnt = 0;
            while (dev_ack != '0 && cnt < 40) begin
                cnt++;
                @(negedge clk);
            end
            chk("R8 dev_ack cycles", cnt, TMO);
        end
        chk("R8 bus_err pulse", bus_err, 1);
        chk("R8 cur_prio unchanged", cur_prio, 2);
        chk("R8 svc_latch unchanged", svc_latch, 5'b00100);

        // R9 withdraw of a pending line
        do_rti();
        chk("R10 cur_prio to idle", cur_prio, 0);
        wait_irq("R9 line3 offered");
        dev_req[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 offer withdrawn", cpu_irq, 0);
        cpu_ack = 1'b1;
        @(negedge clk);
        chk("R9 stray ack no dev_ack", dev_ack, 0);
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R9 stray ack no dev_ack later", dev_ack, 0);
        tick(2);

        do_rti();
        chk("R10 rti at level 0 no effect", cur_prio, 0);

        // R11 nesting overflow
        dev_req[3] = 1'b1;
        serve_dev(3, 8'h33, "R11 nest line3");
        dev_req[2] = 1'b1;
        serve_dev(2, 8'h32, "R11 nest line2");
        dev_req[1] = 1'b1;
        serve_dev(1, 8'h31, "R11 nest line1");
        dev_req[0] = 1'b1;
        serve_dev(0, 8'h30, "R11 nest line0");
        chk("R11 no overflow at depth", stack_ovf, 0);
        nmi_req = 1'b1;
        serve_nmi("R3 nmi over level 4");
        chk("R11 overflow flagged", stack_ovf, 1);
        dev_req = '0;
        nmi_req = 1'b0;
        tick(3);
        do_rti();
        chk("R11 discarded save", cur_prio, 3);
        chk("R11 overflow sticky", stack_ovf, 1);
        do_rti();
        do_rti();
        do_rti();
        chk("R10 unwound to idle", cur_prio, 0);
        tick(3);
        chk("R7 all expected events seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule